// File: doc/BRIEF.md
# Self-Test Fail Status Capture

This block holds the failure record of a logic self-test controller that runs its test segments in sequence. Per-interval fail pulses arrive from outside: a signature mismatch on core 1, a signature mismatch on core 2, and a timeout. The current segment number arrives with them. The first failing interval of a run is latched into a 32-bit status word. The block then raises a one-cycle stop request so that the controller skips the remaining segments.

Software reads the word over a simple register bus. It clears the fail flags by writing ones, and only privileged writes do so. Each time the enable key moves from any other code to the enabled code, a new run starts. The start clears the three flags and the segment field, and it re-arms the capture.

Top module: `stfail_status`

## Requirements
- R1: After the active-low asynchronous reset, the status word reads 0 and `stop_o` is low.
- R2: Status bits 31..5 always read 0. Writes cannot change them, and writes cannot change the segment field at bits 4..3.
- R3: On the first fail event of a run, bit 2 is set for a timeout and bits 4..3 take `seg_i` from that same cycle. All of these are visible in the cycle after the event.
- R4: Bit 0 (core 1 mismatch) and bit 1 (core 2 mismatch) are set only when `seg_i` is 0. A mismatch in another segment still fails the run and records the segment, but it leaves bits 0 and 1 clear.
- R5: The first fail event pulses `stop_o` high for exactly one cycle, in the cycle after the event. Further fail events in the same run change nothing.
- R6: A privileged write to `REG_ADDR` clears each of bits 0..2 whose write-data bit is 1 and keeps each bit whose write-data bit is 0.
- R7: A write with `priv_i` low changes nothing and raises no error.
- R8: When a fail event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: A change of `key_i` from any other code to `KEY_ON` (default 4'hA) clears bits 0..4 and re-arms capture for a new run.
- R10: Fail pulses are ignored while `key_i` differs from `KEY_ON`.
- R11: `rdata_o` shows the status word only during a read (`req_i`=1, `we_i`=0) addressed to `REG_ADDR` (default 8'h20). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | KEY_W | Enable key; `KEY_ON` means enabled |
| seg_i | input | SEG_W | Segment currently under test |
| core1_mis_i | input | 1 | Core 1 signature mismatch pulse |
| core2_mis_i | input | 1 | Core 2 signature mismatch pulse |
| tmo_i | input | 1 | Timeout pulse |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| priv_i | input | 1 | Access is privileged |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| stop_o | output | 1 | One-cycle request to end the run |

## Verification
The fail inputs are driven in four patterns, each of which separates a different rule:
- Both core mismatches together in segment 0 show that the core flags are captured.
- A core mismatch in segment 1 shows that the core flags depend on the segment, while the run still fails and its segment is recorded.
- A timeout in segment 1 shows that the timeout flag is captured independently of the segment.
- A timeout in segment 0 arriving together with a clearing write shows that the fail event has priority over the clear.

Late pulses after a failure, and pulses while the key is off, show whether the capture is really limited to the first event of an armed run. Writes of chosen masks, with and without privilege, separate per-bit clearing from whole-word clearing and from ignored writes.

// File: rtl/stfs_pkg.sv
package stfs_pkg;
  localparam int unsigned FAIL_N = 3;
  localparam int unsigned SEG_W  = 2;
  localparam int unsigned WORD_W = FAIL_N + SEG_W;

  localparam int unsigned IDX_CORE1 = 0;
  localparam int unsigned IDX_CORE2 = 1;
  localparam int unsigned IDX_TMO   = 2;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic             tmo;
    logic             core2;
    logic             core1;
  } stfs_word_t;
endpackage

// File: rtl/stfs_run_ctl.sv
module stfs_run_ctl #(
  parameter int unsigned KEY_W  = 4,
  parameter logic [KEY_W-1:0] KEY_ON = 4'hA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic             fail_any_i,
  output logic             start_o,
  output logic             first_fail_o,
  output logic             stop_o
);
  logic [KEY_W-1:0] key_q;
  logic             done_q;
  logic             stop_q;
  logic             armed;

  assign armed        = (key_i == KEY_ON);
  assign start_o      = armed && (key_q != KEY_ON);
  // a new run re-arms in its first cycle
  assign first_fail_o = armed && fail_any_i && (!done_q || start_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      key_q  <= key_i;
      stop_q <= first_fail_o;
      if (first_fail_o)  done_q <= 1'b1;
      else if (start_o)  done_q <= 1'b0;
    end
  end

  assign stop_o = stop_q;
endmodule

// File: rtl/stfs_bus_dec.sv
module stfs_bus_dec
  import stfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  stfs_word_t        status_i,
  output logic [FAIL_N-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit;
  logic unused_w;

  assign hit      = req_i && (addr_i == REG_ADDR);
  assign clr_o    = (hit && we_i && priv_i) ? wdata_i[FAIL_N-1:0] : '0;
  assign rdata_o  = (hit && !we_i) ? DATA_W'(status_i) : '0;
  assign unused_w = ^wdata_i[DATA_W-1:FAIL_N];
endmodule

// File: rtl/stfs_flag_bank.sv
module stfs_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          bit_q <= 1'b0;
      else if (set_i[b])    bit_q <= 1'b1;   // set beats clear
      else if (clr_i[b])    bit_q <= 1'b0;
    end
    assign q_o[b] = bit_q;
  end
endmodule

// File: rtl/stfail_status.sv
module stfail_status
  import stfs_pkg::*;
#(
  parameter int unsigned KEY_W  = 4,
  parameter logic [KEY_W-1:0] KEY_ON = 4'hA,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              core1_mis_i,
  input  logic              core2_mis_i,
  input  logic              tmo_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stop_o
);
  logic              start;
  logic              first_fail;
  logic              seg_zero;
  logic [FAIL_N-1:0] ev;
  logic [FAIL_N-1:0] set_v;
  logic [FAIL_N-1:0] bus_clr;
  logic [FAIL_N-1:0] clr_v;
  logic [FAIL_N-1:0] flags_q;
  logic [SEG_W-1:0]  seg_q;
  stfs_word_t        st_q;

  assign seg_zero        = (seg_i == '0);
  assign ev[IDX_CORE1]   = core1_mis_i;
  assign ev[IDX_CORE2]   = core2_mis_i;
  assign ev[IDX_TMO]     = tmo_i;

  stfs_run_ctl #(.KEY_W(KEY_W), .KEY_ON(KEY_ON)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_i       (key_i),
    .fail_any_i  (|ev),
    .start_o     (start),
    .first_fail_o(first_fail),
    .stop_o      (stop_o)
  );

  // core flags are only meaningful for segment 0
  always_comb begin
    set_v = '0;
    if (first_fail) begin
      set_v[IDX_TMO]   = ev[IDX_TMO];
      set_v[IDX_CORE1] = ev[IDX_CORE1] && seg_zero;
      set_v[IDX_CORE2] = ev[IDX_CORE2] && seg_zero;
    end
  end

  assign clr_v = start ? '1 : bus_clr;

  stfs_flag_bank #(.N(FAIL_N)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seg_q <= '0;
    else if (first_fail) seg_q <= seg_i;
    else if (start)      seg_q <= '0;
  end

  assign st_q = {seg_q, flags_q};

  stfs_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_bus (
    .req_i   (req_i),
    .we_i    (we_i),
    .priv_i  (priv_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(st_q),
    .clr_o   (bus_clr),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/stfs_checker.sv
module stfs_checker
  import stfs_pkg::*;
#(
  parameter int unsigned KEY_W  = 4,
  parameter logic [KEY_W-1:0] KEY_ON = 4'hA,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [KEY_W-1:0]  key_i,
  input logic              core1_mis_i,
  input logic              core2_mis_i,
  input logic              tmo_i,
  input logic              req_i,
  input logic              we_i,
  input logic              priv_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              stop_o,
  input stfs_word_t        st_i
);
  localparam int unsigned RSVD_LSB = WORD_W;

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:RSVD_LSB] == '0);

  assert_core_seg0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.core1 || st_i.core2) |-> (st_i.seg == '0));

  assert_stop_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);

  assert_stop_recorded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (st_i != '0));

  assert_nopriv_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !priv_i && !(core1_mis_i || core2_mis_i || tmo_i) && $stable(key_i))
    |=> $stable(st_i));

  assert_key_off_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_i != KEY_ON && !(req_i && we_i)) |=> $stable(st_i));
endmodule

bind stfail_status stfs_checker #(.KEY_W(KEY_W), .KEY_ON(KEY_ON), .DATA_W(DATA_W)) u_stfs_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_i      (key_i),
  .core1_mis_i(core1_mis_i),
  .core2_mis_i(core2_mis_i),
  .tmo_i      (tmo_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .priv_i     (priv_i),
  .rdata_o    (rdata_o),
  .stop_o     (stop_o),
  .st_i       (st_q)
);

// File: tb/test_stfail_status.sv
module test_stfail_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] K_ON  = 4'hA;
  localparam logic [3:0] K_OFF = 4'h5;
  localparam logic [7:0] RA    = 8'h20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  key_i = K_OFF;
  logic [1:0]  seg_i = 2'd0;
  logic        core1_mis_i = 1'b0, core2_mis_i = 1'b0, tmo_i = 1'b0;
  logic        req_i = 1'b1, we_i = 1'b0, priv_i = 1'b0;
  logic [7:0]  addr_i = RA;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        stop_o;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stfail_status i_stfail_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_i(key_i), .seg_i(seg_i),
    .core1_mis_i(core1_mis_i), .core2_mis_i(core2_mis_i), .tmo_i(tmo_i),
    .req_i(req_i), .we_i(we_i), .priv_i(priv_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .stop_o(stop_o)
  );

  // reference model
  bit       m_c1, m_c2, m_to, m_done, m_stop;
  int       m_seg;
  bit [3:0] m_kprev;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_c1 <= 0; m_c2 <= 0; m_to <= 0; m_done <= 0; m_stop <= 0; m_seg <= 0; m_kprev <= 0;
    end else begin
      bit on, newrun, fire;
      bit [2:0] wipe;
      on     = (key_i == K_ON);
      newrun = on && (m_kprev != K_ON);
      fire   = on && (core1_mis_i || core2_mis_i || tmo_i) && (!m_done || newrun);
      wipe   = 3'b000;
      if (newrun) wipe = 3'b111;
      else if (req_i && we_i && priv_i && addr_i == RA) wipe = wdata_i[2:0];
      m_c1 <= (fire && core1_mis_i && seg_i == 0) || (m_c1 && !wipe[0]);
      m_c2 <= (fire && core2_mis_i && seg_i == 0) || (m_c2 && !wipe[1]);
      m_to <= (fire && tmo_i) || (m_to && !wipe[2]);
      if (fire) m_seg <= seg_i;
      else if (newrun) m_seg <= 0;
      m_done  <= fire ? 1'b1 : (newrun ? 1'b0 : m_done);
      m_stop  <= fire;
      m_kprev <= key_i;
    end
  end

  function automatic logic [31:0] model_rdata();
    if (req_i && !we_i && addr_i == RA)
      return {27'd0, 2'(m_seg), m_to, m_c2, m_c1};
    return 32'd0;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      checks++;
      if (rdata_o !== model_rdata() || stop_o !== m_stop) begin
        errors++;
        $display("FAIL %s model: rdata=%h stop=%b expected rdata=%h stop=%b",
                 phase, rdata_o, stop_o, model_rdata(), m_stop);
      end
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    core1_mis_i = 0; core2_mis_i = 0; tmo_i = 0;
    req_i = 1; we_i = 0; priv_i = 0; addr_i = RA; wdata_i = '0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic pv, logic [31:0] d);
    req_i = 1; we_i = 1; priv_i = pv; wdata_i = d;
    tick();
    idle();
    #1;
  endtask

  task automatic pulse(logic [1:0] s, logic a, logic b, logic t);
    seg_i = s; core1_mis_i = a; core2_mis_i = b; tmo_i = t;
    tick();
    idle();
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    idle();
    repeat (3) tick();
    phase = "R1";
    chk("R1 reset status", rdata_o, 32'h0);
    chk("R1 reset stop", {31'd0, stop_o}, 32'h0);
    rst_ni = 1;
    tick();

    phase = "R10";
    pulse(2'd0, 1, 1, 1);
    chk("R10 key off ignored", rdata_o, 32'h0);
    chk("R10 no stop", {31'd0, stop_o}, 32'h0);

    phase = "R3";
    key_i = K_ON;
    tick(); tick();
    pulse(2'd0, 1, 1, 0);
    chk("R3 core flags seg0", rdata_o, 32'h03);
    chk("R5 stop pulse", {31'd0, stop_o}, 32'h1);
    tick();
    chk("R5 stop single", {31'd0, stop_o}, 32'h0);
    phase = "R5";
    pulse(2'd1, 0, 0, 1);
    chk("R5 later event ignored", rdata_o, 32'h03);

    phase = "R7";
    wr(0, 32'h7);
    chk("R7 unprivileged write", rdata_o, 32'h03);

    phase = "R6";
    wr(1, 32'h1);
    chk("R6 clear bit0 only", rdata_o, 32'h02);
    wr(1, 32'h2);
    chk("R6 clear bit1", rdata_o, 32'h00);

    phase = "R4";
    key_i = K_OFF; tick(); key_i = K_ON; tick();
    pulse(2'd1, 1, 0, 0);
    chk("R4 seg1 mismatch no core flag", rdata_o, 32'h08);
    phase = "R2";
    wr(1, 32'hFFFF_FFFF);
    chk("R2 reserved and segment unwritable", rdata_o, 32'h08);

    phase = "R9";
    key_i = K_OFF; tick(); key_i = K_ON; tick();
    chk("R9 new run clears", rdata_o, 32'h00);
    pulse(2'd1, 0, 0, 1);
    chk("R3 timeout seg1", rdata_o, 32'h0C);
    key_i = K_OFF; tick(); key_i = K_ON; tick();
    chk("R9 clears timeout and segment", rdata_o, 32'h00);

    phase = "R8";
    seg_i = 2'd0; tmo_i = 1; req_i = 1; we_i = 1; priv_i = 1; wdata_i = 32'h4;
    tick();
    idle();
    #1;
    chk("R8 set beats clear", rdata_o, 32'h04);

    phase = "R11";
    addr_i = 8'h24;
    #1;
    chk("R11 other address reads zero", rdata_o, 32'h0);
    addr_i = RA; req_i = 0;
    #1;
    chk("R11 no request reads zero", rdata_o, 32'h0);
    idle();
    repeat (3) tick();
    summary();
  end
endmodule